// File: doc/BRIEF.md
# Counted-Enable Interrupt Aggregator

This block collects a fixed set of level-driven interrupt sources and combines them into one interrupt request to the processor. A source is not enabled by a single mask bit. Each source keeps a small enable counter, and a register bank moves that counter up or down with one-cycle pulses. The source is enabled only while the counter sits exactly at a maximum fixed for that source. Several independent enable conditions (a mask, a group switch, a priority field) can therefore all have to agree before the source may interrupt.

A source is pending while its level is asserted and it is enabled. A running count of pending sources drives the processor request line: the line rises when the count leaves zero and falls when the count returns to zero. When the processor pulses a query, the block answers on the next cycle with the vector of the lowest-numbered pending source. It answers "no interrupt" when the processor's interrupt mask is fully closed or when nothing is pending. Source 0 is reserved and never becomes pending.

Top module: `irq_aggregator`

## Requirements
- R1: Each source's enable counter resets to 0 and changes on the clock edge that samples its pulses. An increment alone adds one but never goes above that source's maximum. A decrement alone subtracts one but never goes below 0. Both pulses together, or neither, leave the counter unchanged.
- R2: A source is pending exactly when its registered level is high and its enable counter equals its maximum. A source whose counter is below its maximum never raises the request.
- R3: The pending count changes by the number of sources that became pending minus the number that stopped being pending. This holds even when several sources change in the same cycle, so a rise on one source and a fall on another in the same cycle leave the count unchanged.
- R4: `cpu_irq` is high exactly when the pending count is nonzero. It follows a change in pending state one clock later, which is two clock edges after a level change on an enabled source.
- R5: Each level input is registered once per clock. A source becomes asserted on a low-to-high change and deasserted on a high-to-low change, and a level held steady causes no further change.
- R6: A query made while `imask` equals 4'hF returns `vec_valid` = 0, even when sources are pending.
- R7: A query made while `imask` is not 4'hF is answered one clock later. `vec_valid` = 1 and `vec_out` carries the vector of the lowest-indexed pending source, or `vec_valid` = 0 if no source is pending. `vec_valid` is 0 in every cycle that does not follow a query.
- R8: Source 0 never becomes pending, whatever its level and enable pulses.
- R9: After reset all counters are 0, no source is asserted, and `cpu_irq`, `vec_valid` and `vec_out` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_level | input | N | Level request of each source |
| en_inc | input | N | One-cycle enable increment pulse per source |
| en_dec | input | N | One-cycle enable decrement pulse per source |
| query | input | 1 | Processor vector query strobe |
| imask | input | 4 | Processor interrupt mask level at query time |
| cpu_irq | output | 1 | Interrupt request to the processor |
| vec_out | output | 16 | Vector of the selected pending source |
| vec_valid | output | 1 | One-cycle response: a vector is being returned |

## Verification
The enable path is driven with sources whose maxima differ (1 and 2). Stepping one counter up to its maximum and back shows that the request needs every enable step and not just one. Repeated increments at the top and repeated decrements at zero, followed by a single opposite step, tell a saturating counter apart from one that wraps or overshoots. Two sources rising together, then one rising while the other falls in the same cycle, separate a net-difference count from one that handles a single change per cycle. Queries with several sources pending, with one pending, with none pending and with the mask closed tell apart the lowest-index choice, the empty answer and the mask override.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int VEC_W = 16;
    localparam int MASK_W = 4;
    localparam logic [MASK_W-1:0] IMASK_CLOSED = 4'hF;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } en_step_t;

    typedef struct packed {
        logic             valid;
        logic [VEC_W-1:0] vec;
    } vec_resp_t;

    function automatic en_step_t decode_step(input logic inc, input logic dec);
        if (inc && !dec) return STEP_UP;
        if (dec && !inc) return STEP_DOWN;
        return STEP_HOLD;
    endfunction

    function automatic logic [6:0] ones64(input logic [63:0] v);
        logic [6:0] acc;
        acc = '0;
        for (int i = 0; i < 64; i++) acc = acc + {6'd0, v[i]};
        return acc;
    endfunction

endpackage

// File: rtl/irq_src_slot.sv
module irq_src_slot
    import irq_agg_pkg::*;
#(
    parameter int CNT_W = 2,
    parameter logic [CNT_W-1:0] EN_MAX = 1,
    parameter bit RESERVED = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             level,
    input  logic             inc,
    input  logic             dec,
    output logic             asserted,
    output logic             pending,
    output logic [CNT_W-1:0] en_cnt
);
    en_step_t step;
    assign step = decode_step(inc, dec);

    always_ff @(posedge clk) begin
        if (rst) begin
            asserted <= 1'b0;
            en_cnt   <= '0;
        end else begin
            if (level && !asserted)      asserted <= 1'b1;
            else if (!level && asserted) asserted <= 1'b0;
            unique case (step)
                STEP_UP:   if (en_cnt != EN_MAX) en_cnt <= en_cnt + 1'b1;
                STEP_DOWN: if (en_cnt != '0)     en_cnt <= en_cnt - 1'b1;
                default:   en_cnt <= en_cnt;
            endcase
        end
    end

    generate
        if (RESERVED) begin : g_reserved
            assign pending = 1'b0;
        end else begin : g_live
            assign pending = asserted && (en_cnt == EN_MAX);
        end
    endgenerate
endmodule

// File: rtl/irq_pend_count.sv
module irq_pend_count
    import irq_agg_pkg::*;
#(
    parameter int N = 8,
    localparam int CW = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  pending,
    output logic [CW-1:0] count,
    output logic [N-1:0]  pend_seen,
    output logic          irq
);
    logic [N-1:0]  rises, falls;
    logic [CW-1:0] count_next;

    assign rises = pending & ~pend_seen;
    assign falls = ~pending & pend_seen;
    assign count_next = count + CW'(ones64(64'(rises))) - CW'(ones64(64'(falls)));

    always_ff @(posedge clk) begin
        if (rst) begin
            count     <= '0;
            pend_seen <= '0;
            irq       <= 1'b0;
        end else begin
            count     <= count_next;
            pend_seen <= pending;
            irq       <= (count_next != '0);
        end
    end
endmodule

// File: rtl/irq_vec_pick.sv
module irq_vec_pick
    import irq_agg_pkg::*;
#(
    parameter int N = 8,
    parameter logic [N*VEC_W-1:0] VEC_ALL = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              query,
    input  logic [MASK_W-1:0] imask,
    input  logic [N-1:0]      pending,
    output vec_resp_t         resp
);
    vec_resp_t pick;

    always_comb begin
        pick = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pending[i]) begin
                pick.valid = 1'b1;
                pick.vec   = VEC_ALL[i*VEC_W +: VEC_W];
            end
        end
        if (imask == IMASK_CLOSED) pick = '0;
    end

    always_ff @(posedge clk) begin
        if (rst)        resp <= '0;
        else if (query) resp <= pick;
        else            resp <= '0;
    end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int N = 8,
    parameter int CNT_W = 2,
    parameter logic [N*CNT_W-1:0] EN_MAX_ALL = 16'h59E5,
    parameter logic [N*16-1:0] VEC_ALL =
        128'h04E0_04C0_04A0_0480_0460_0440_0420_0400,
    localparam int CW = $clog2(N + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] src_level,
    input  logic [N-1:0] en_inc,
    input  logic [N-1:0] en_dec,
    input  logic         query,
    input  logic [3:0]   imask,
    output logic         cpu_irq,
    output logic [15:0]  vec_out,
    output logic         vec_valid
);
    logic [N-1:0]       src_asserted;
    logic [N-1:0]       src_pending;
    logic [N*CNT_W-1:0] en_cnt_all;
    logic [CW-1:0]      pend_count;
    logic [N-1:0]       pend_seen;
    vec_resp_t          resp;

    for (genvar g = 0; g < N; g++) begin : g_src
        irq_src_slot #(
            .CNT_W   (CNT_W),
            .EN_MAX  (EN_MAX_ALL[g*CNT_W +: CNT_W]),
            .RESERVED(g == 0)
        ) slot_i (
            .clk     (clk),
            .rst     (rst),
            .level   (src_level[g]),
            .inc     (en_inc[g]),
            .dec     (en_dec[g]),
            .asserted(src_asserted[g]),
            .pending (src_pending[g]),
            .en_cnt  (en_cnt_all[g*CNT_W +: CNT_W])
        );
    end

    irq_pend_count #(.N(N)) count_i (
        .clk      (clk),
        .rst      (rst),
        .pending  (src_pending),
        .count    (pend_count),
        .pend_seen(pend_seen),
        .irq      (cpu_irq)
    );

    irq_vec_pick #(.N(N), .VEC_ALL(VEC_ALL)) pick_i (
        .clk    (clk),
        .rst    (rst),
        .query  (query),
        .imask  (imask),
        .pending(src_pending),
        .resp   (resp)
    );

    assign vec_out   = resp.vec;
    assign vec_valid = resp.valid;
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
    parameter int N = 8,
    parameter int CNT_W = 2,
    parameter logic [N*CNT_W-1:0] EN_MAX_ALL = '0,
    localparam int CW = $clog2(N + 1)
) (
    input logic               clk,
    input logic               rst,
    input logic [N-1:0]       src_level,
    input logic [N-1:0]       en_inc,
    input logic [N-1:0]       en_dec,
    input logic               query,
    input logic [3:0]         imask,
    input logic               cpu_irq,
    input logic               vec_valid,
    input logic [N-1:0]       asserted,
    input logic [N-1:0]       pending,
    input logic [N*CNT_W-1:0] en_cnt_all,
    input logic [CW-1:0]      pend_count,
    input logic [N-1:0]       pend_seen
);
    for (genvar g = 0; g < N; g++) begin : g_chk
        assert_cnt_bounded_R1: assert property (@(posedge clk) disable iff (rst)
            en_cnt_all[g*CNT_W +: CNT_W] <= EN_MAX_ALL[g*CNT_W +: CNT_W]);
        assert_both_pulses_hold_R1: assert property (@(posedge clk) disable iff (rst)
            (en_inc[g] && en_dec[g]) |=> $stable(en_cnt_all[g*CNT_W +: CNT_W]));
        assert_level_tracked_R5: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> (asserted[g] == $past(src_level[g])));
    end

    assert_count_matches_R3: assert property (@(posedge clk) disable iff (rst)
        pend_count == CW'($countones(pend_seen)));
    assert_irq_rise_cause_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_irq) |-> $past(pending != '0));
    assert_irq_vs_count_R4: assert property (@(posedge clk) disable iff (rst)
        cpu_irq == (pend_count != '0));
    assert_closed_mask_R6: assert property (@(posedge clk) disable iff (rst)
        (query && imask == 4'hF) |=> !vec_valid);
    assert_valid_needs_query_R7: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> $past(query));
    assert_reserved_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !pend_seen[0]);
endmodule

bind irq_aggregator irq_aggregator_chk #(
    .N(N), .CNT_W(CNT_W), .EN_MAX_ALL(EN_MAX_ALL)
) chk_i (
    .clk(clk), .rst(rst), .src_level(src_level), .en_inc(en_inc), .en_dec(en_dec),
    .query(query), .imask(imask), .cpu_irq(cpu_irq), .vec_valid(vec_valid),
    .asserted(src_asserted), .pending(src_pending), .en_cnt_all(en_cnt_all),
    .pend_count(pend_count), .pend_seen(pend_seen)
);

// File: tb/irq_aggregator_tb_top.sv
module irq_aggregator_tb_top;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] src_level = '0;
    logic [N-1:0] en_inc = '0;
    logic [N-1:0] en_dec = '0;
    logic         query = 1'b0;
    logic [3:0]   imask = 4'h0;
    logic         cpu_irq;
    logic [15:0]  vec_out;
    logic         vec_valid;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_aggregator dut_i (
        .clk(clk), .rst(rst), .src_level(src_level), .en_inc(en_inc),
        .en_dec(en_dec), .query(query), .imask(imask), .cpu_irq(cpu_irq),
        .vec_out(vec_out), .vec_valid(vec_valid)
    );

    // Vector of source i by default: 16'h0400 + 16'h0020 * i
    function automatic logic [15:0] vec_of(input int i);
        return 16'h0400 + 16'(i * 32);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic pulse(input logic [N-1:0] inc, input logic [N-1:0] dec);
        @(negedge clk);
        en_inc = inc;
        en_dec = dec;
        @(negedge clk);
        en_inc = '0;
        en_dec = '0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic ask(input logic [3:0] m, output logic v, output logic [15:0] vec);
        @(negedge clk);
        query = 1'b1;
        imask = m;
        @(negedge clk);
        query = 1'b0;
        v = vec_valid;
        vec = vec_out;
    endtask

    task automatic t_reset();
        logic v;
        logic [15:0] vec;
        check(cpu_irq == 1'b0, "R9", "irq after reset", cpu_irq, 0);
        check(vec_valid == 1'b0 && vec_out == 16'h0, "R9", "vec after reset", vec_out, 0);
        ask(4'h0, v, vec);
        check(v == 1'b0, "R7", "query with none pending", v, 0);
    endtask

    task automatic t_enable_path();
        // source 2, maximum 2
        src_level[2] = 1'b1;
        settle();
        check(cpu_irq == 1'b0, "R2", "asserted, counter 0 of 2", cpu_irq, 0);
        pulse(8'h04, 8'h00);
        settle();
        check(cpu_irq == 1'b0, "R2", "asserted, counter 1 of 2", cpu_irq, 0);
        pulse(8'h04, 8'h00);
        settle();
        check(cpu_irq == 1'b1, "R2", "asserted, counter 2 of 2", cpu_irq, 1);
        pulse(8'h00, 8'h04);
        settle();
        check(cpu_irq == 1'b0, "R2", "counter back to 1", cpu_irq, 0);
        src_level[2] = 1'b0;
        pulse(8'h00, 8'h04);
        settle();
    endtask

    task automatic t_saturate();
        // source 1, maximum 1
        pulse(8'h00, 8'h02);
        pulse(8'h00, 8'h02);
        pulse(8'h02, 8'h00);
        src_level[1] = 1'b1;
        settle();
        check(cpu_irq == 1'b1, "R1", "floor at 0 then one increment", cpu_irq, 1);
        pulse(8'h02, 8'h00);
        settle();
        check(cpu_irq == 1'b1, "R1", "increment at maximum holds", cpu_irq, 1);
        pulse(8'h02, 8'h02);
        settle();
        check(cpu_irq == 1'b1, "R1", "both pulses hold", cpu_irq, 1);
        pulse(8'h00, 8'h02);
        settle();
        check(cpu_irq == 1'b0, "R1", "decrement disables", cpu_irq, 0);
        src_level[1] = 1'b0;
        settle();
    endtask

    task automatic t_timing();
        // source 7, maximum 1: irq two edges after the level change
        pulse(8'h80, 8'h00);
        @(negedge clk);
        src_level[7] = 1'b1;
        @(negedge clk);
        check(cpu_irq == 1'b0, "R4", "irq one edge after level", cpu_irq, 0);
        @(negedge clk);
        check(cpu_irq == 1'b1, "R4", "irq two edges after level", cpu_irq, 1);
        src_level[7] = 1'b0;
        @(negedge clk);
        check(cpu_irq == 1'b1, "R5", "fall seen after one edge only", cpu_irq, 1);
        @(negedge clk);
        check(cpu_irq == 1'b0, "R4", "irq drops two edges after fall", cpu_irq, 0);
    endtask

    task automatic t_multi();
        logic v;
        logic [15:0] vec;
        // sources 4 and 6, maximum 1 each
        pulse(8'h50, 8'h00);
        @(negedge clk);
        src_level[4] = 1'b1;
        src_level[6] = 1'b1;
        settle();
        check(cpu_irq == 1'b1, "R3", "two rise together", cpu_irq, 1);
        ask(4'h3, v, vec);
        check(v && vec == vec_of(4), "R7", "lowest of 4 and 6", vec, vec_of(4));
        @(negedge clk);
        check(vec_valid == 1'b0, "R7", "valid only after query", vec_valid, 0);
        ask(4'hF, v, vec);
        check(v == 1'b0, "R6", "closed mask with pending", v, 0);
        src_level[4] = 1'b0;
        settle();
        check(cpu_irq == 1'b1, "R3", "one of two fell", cpu_irq, 1);
        ask(4'h0, v, vec);
        check(v && vec == vec_of(6), "R7", "only 6 pending", vec, vec_of(6));
        @(negedge clk);
        src_level[4] = 1'b1;
        src_level[6] = 1'b0;
        settle();
        check(cpu_irq == 1'b1, "R3", "rise and fall same cycle", cpu_irq, 1);
        src_level[4] = 1'b0;
        settle();
        check(cpu_irq == 1'b0, "R3", "last source fell", cpu_irq, 0);
        ask(4'h0, v, vec);
        check(v == 1'b0, "R7", "none pending after all fell", v, 0);
    endtask

    task automatic t_reserved();
        logic v;
        logic [15:0] vec;
        pulse(8'h01, 8'h00);
        src_level[0] = 1'b1;
        settle();
        check(cpu_irq == 1'b0, "R8", "source 0 irq", cpu_irq, 0);
        ask(4'h0, v, vec);
        check(v == 1'b0, "R8", "source 0 vector", v, 0);
        src_level[0] = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_enable_path();
        t_saturate();
        t_timing();
        t_multi();
        t_reserved();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule